// File: doc/BRIEF.md
# Configurable Register Macrocell

This block is one output cell of a programmable logic array. A sum-of-products term arrives on `sum_in`. The cell can invert it under a configuration bit, then passes it through one storage stage. Two configuration bits select how that stage behaves: a plain wire, an edge-triggered data flop, an edge-triggered toggle flop, or a level-sensitive latch. The stage is timed by one of several global clocks, chosen by a select field.

The cell's value always goes out on `fb_out`, which leads back into the routing fabric. The cell also has a pin-facing output, `pin_out`. The parameter `IS_BURIED` picks one of two variants:

- **Pin variant (`IS_BURIED` = 0):** the cell value drives `pin_out`.
- **Buried variant (`IS_BURIED` = 1):** `pin_out` is held low. The cell can be switched into an input-register role. In that role it stores the adjacent cell's pin input instead of the sum term, so the cell keeps working while the neighbouring pin acts as an input.

Top module: `cfg_cell`

## Requirements
- R1: While `rst` is 1, a rising edge of the selected clock clears the flop state to 0, and a high level of the selected clock clears the latch state to 0. This applies in every mode, so that after reset `fb_out` reads 0 in modes 01, 10 and 11.
- R2: With `mode` = 00 (pass-through), `fb_out` follows the polarity-adjusted sum term with no clock edge needed.
- R3: With `mode` = 01 (data flop), a rising edge of the selected clock loads the polarity-adjusted input, and `fb_out` holds it until the next such edge.
- R4: When `invert` = 1, the sum term is complemented before it reaches the storage stage or the pass-through path.
- R5: With `mode` = 10 (toggle flop), a rising edge of the selected clock inverts the state when the polarity-adjusted input is 1 and keeps it when the input is 0.
- R6: With `mode` = 11 (latch), the state follows the input while the selected clock is high and keeps its value while that clock is low.
- R7: Only `gclk[clk_sel]` times the storage stage. Edges on any other global clock leave `fb_out` unchanged.
- R8: In the buried variant with `src_pin` = 1, the stored input is `nbr_pin` taken as is, with `invert` having no effect. In this role mode 11 acts as a latch and every other mode acts as a data flop.
- R9: `fb_out` always carries the cell value. In the buried variant `pin_out` stays 0. In the pin variant `pin_out` equals `fb_out`, and `src_pin` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| gclk | input | N_CLK | Global clocks |
| clk_sel | input | SEL_W | Index of the global clock that times the cell |
| rst | input | 1 | Reset, active high, acting through the selected clock |
| mode | input | 2 | Storage behaviour: 00 pass, 01 data flop, 10 toggle flop, 11 latch |
| invert | input | 1 | Complement the sum term |
| src_pin | input | 1 | Store the adjacent pin input instead (buried variant only) |
| sum_in | input | 1 | Sum term from the product-term array |
| nbr_pin | input | 1 | Adjacent cell's pin input |
| pin_out | output | 1 | Pin-facing output |
| fb_out | output | 1 | Feedback into the routing fabric |

## Verification
The assertions check the following on every cycle:

- on each selected-clock edge, the data-flop load and the toggle rule;
- that the flop reads 0 on the first edge after reset is released;
- that the latch holds the input value when its clock falls;
- that the pass-through output equals the adjusted input at each edge.

Some behaviours can only be shown by the bench's scenarios:

- that edges on the unselected clock are ignored;
- that polarity does not reach the pin input in the input-register role;
- that the latch holds while its clock is low;
- that the two variants drive `pin_out` differently.

// File: rtl/cfg_cell_pkg.sv
package cfg_cell_pkg;

  typedef enum logic [1:0] {
    CM_PASS  = 2'b00,
    CM_DFF   = 2'b01,
    CM_TFF   = 2'b10,
    CM_LATCH = 2'b11
  } cell_mode_e;

  // Data reaching the storage stage: pin input raw, or the sum term with polarity.
  function automatic logic cell_data(input logic use_pin, input logic inv,
                                     input logic sum, input logic pin);
    return use_pin ? pin : (sum ^ inv);
  endfunction

  // In the input-register role only a data flop or a latch is meaningful.
  function automatic cell_mode_e cell_mode(input logic use_pin, input logic [1:0] m);
    cell_mode_e r;
    r = cell_mode_e'(m);
    if (use_pin && (r != CM_LATCH)) r = CM_DFF;
    return r;
  endfunction

  // Next flop state on a selected-clock edge.
  function automatic logic flop_next(input cell_mode_e m, input logic q, input logic d);
    logic n;
    case (m)
      CM_DFF:  n = d;
      CM_TFF:  n = q ^ d;
      default: n = q;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/cell_clk_pick.sv
module cell_clk_pick #(
  parameter int N_CLK = 2,
  localparam int SEL_W = (N_CLK > 1) ? $clog2(N_CLK) : 1
) (
  input  logic [N_CLK-1:0] gclk,
  input  logic [SEL_W-1:0] clk_sel,
  output logic             sclk
);
  always_comb sclk = gclk[clk_sel];
endmodule

// File: rtl/cell_front.sv
module cell_front
  import cfg_cell_pkg::*;
#(
  parameter bit ALLOW_PIN = 1'b1
) (
  input  logic       [1:0] mode,
  input  logic             invert,
  input  logic             src_pin,
  input  logic             sum_in,
  input  logic             nbr_pin,
  output cell_mode_e       mode_eff,
  output logic             d
);
  logic use_pin;
  assign use_pin  = src_pin & ALLOW_PIN;
  assign d        = cell_data(use_pin, invert, sum_in, nbr_pin);
  assign mode_eff = cell_mode(use_pin, mode);
endmodule

// File: rtl/cell_store.sv
module cell_store
  import cfg_cell_pkg::*;
(
  input  logic       sclk,
  input  logic       rst,
  input  cell_mode_e mode_eff,
  input  logic       d,
  output logic       q
);
  logic q_ff;
  logic q_lat;

  // Edge-triggered state shared by the data and toggle modes.
  always_ff @(posedge sclk) begin
    if (rst) q_ff <= 1'b0;
    else     q_ff <= flop_next(mode_eff, q_ff, d);
  end

  // Level-sensitive state, open while the selected clock is high.
  always_latch begin
    if (sclk) begin
      if (rst)                       q_lat = 1'b0;
      else if (mode_eff == CM_LATCH) q_lat = d;
    end
  end

  always_comb begin
    case (mode_eff)
      CM_PASS:  q = d;
      CM_LATCH: q = q_lat;
      default:  q = q_ff;
    endcase
  end

  // R3: data flop loads its input
  a_r3_dff_load: assert property (@(posedge sclk) disable iff (rst)
    (mode_eff == CM_DFF) |=> (q_ff == $past(d)));

  // R5: toggle rule
  a_r5_tff_rule: assert property (@(posedge sclk) disable iff (rst)
    (mode_eff == CM_TFF) |=> (q_ff == ($past(q_ff) ^ $past(d))));

  // R1: flop cleared by the reset edge
  a_r1_flop_clear: assert property (@(posedge sclk) disable iff (rst)
    $fell(rst) |-> (q_ff == 1'b0));

  // R6: latch holds its input as the clock closes it
  a_r6_latch_close: assert property (@(negedge sclk) disable iff (rst)
    (mode_eff == CM_LATCH) |-> (q_lat == d));

endmodule

// File: rtl/cfg_cell.sv
module cfg_cell
  import cfg_cell_pkg::*;
#(
  parameter int N_CLK     = 2,
  parameter bit IS_BURIED = 1'b1,
  localparam int SEL_W = (N_CLK > 1) ? $clog2(N_CLK) : 1
) (
  input  logic [N_CLK-1:0] gclk,
  input  logic [SEL_W-1:0] clk_sel,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic             invert,
  input  logic             src_pin,
  input  logic             sum_in,
  input  logic             nbr_pin,
  output logic             pin_out,
  output logic             fb_out
);
  logic       sclk;
  logic       d;
  logic       cell_q;
  cell_mode_e mode_eff;

  cell_clk_pick #(.N_CLK(N_CLK)) u_clk (
    .gclk(gclk), .clk_sel(clk_sel), .sclk(sclk)
  );

  cell_front #(.ALLOW_PIN(IS_BURIED)) u_front (
    .mode(mode), .invert(invert), .src_pin(src_pin),
    .sum_in(sum_in), .nbr_pin(nbr_pin),
    .mode_eff(mode_eff), .d(d)
  );

  cell_store u_store (
    .sclk(sclk), .rst(rst), .mode_eff(mode_eff), .d(d), .q(cell_q)
  );

  assign fb_out = cell_q;

  generate
    if (IS_BURIED) begin : g_buried
      assign pin_out = 1'b0;
    end else begin : g_pin
      assign pin_out = cell_q;
    end
  endgenerate

  // R2: pass-through output matches the adjusted input
  a_r2_pass: assert property (@(posedge sclk) disable iff (rst)
    (mode_eff == CM_PASS) |-> (fb_out == d));

endmodule

// File: tb/test_cfg_cell.sv
module test_cfg_cell;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 19;

  logic [1:0] gclk = 2'b00;
  logic       clk_sel = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode = 2'b01;
  logic       invert = 1'b0;
  logic       src_pin = 1'b0;
  logic       sum_in = 1'b0;
  logic       nbr_pin = 1'b0;
  logic       pin_b, fb_b, pin_p, fb_p;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  cfg_cell #(.N_CLK(2), .IS_BURIED(1'b1)) i_cfg_cell (
    .gclk(gclk), .clk_sel(clk_sel), .rst(rst), .mode(mode), .invert(invert),
    .src_pin(src_pin), .sum_in(sum_in), .nbr_pin(nbr_pin),
    .pin_out(pin_b), .fb_out(fb_b)
  );

  cfg_cell #(.N_CLK(2), .IS_BURIED(1'b0)) i_cfg_cell_pin (
    .gclk(gclk), .clk_sel(clk_sel), .rst(rst), .mode(mode), .invert(invert),
    .src_pin(src_pin), .sum_in(sum_in), .nbr_pin(nbr_pin),
    .pin_out(pin_p), .fb_out(fb_p)
  );

  // {mode[1:0], clk_sel, invert, src_pin, sum_in, nbr_pin, pulse[1:0], expected}
  // pulse: 0 none, 1 gclk[0], 2 gclk[1]
  localparam logic [9:0] VEC [NVEC] = '{
    10'b01_0_0_0_1_0_01_1,  // R3 load 1
    10'b01_0_0_0_0_1_10_1,  // R7 other clock ignored
    10'b01_1_0_0_0_0_10_0,  // R7 select gclk[1], load 0
    10'b01_0_1_0_0_0_01_1,  // R4 inverted load
    10'b00_0_0_0_0_0_00_0,  // R2 pass
    10'b00_0_1_0_0_0_00_1,  // R2 R4 pass inverted
    10'b10_0_0_0_0_0_01_1,  // R5 hold
    10'b10_0_0_0_1_0_01_0,  // R5 toggle
    10'b10_0_0_0_1_0_01_1,  // R5 toggle
    10'b10_0_1_0_0_0_01_0,  // R5 R4 toggle via polarity
    10'b11_0_0_0_1_0_01_1,  // R6 latch 1
    10'b11_0_0_0_0_0_00_1,  // R6 hold while low
    10'b11_0_0_0_0_0_10_1,  // R7 latch ignores other clock
    10'b11_0_1_0_1_0_01_0,  // R6 R4 latch 0
    10'b01_0_0_1_0_1_01_1,  // R8 pin captured
    10'b01_0_1_1_1_0_01_0,  // R8 polarity not applied
    10'b11_0_0_1_0_1_01_1,  // R8 pin latch
    10'b00_0_0_1_0_1_01_1,  // R8 pass becomes flop
    10'b10_0_0_1_0_1_01_1   // R8 toggle becomes flop
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic pulse(input int which);
    if (which == 1) gclk[0] = 1'b1;
    else if (which == 2) gclk[1] = 1'b1;
    #(CLK_PERIOD/2);
    gclk = 2'b00;
    #(CLK_PERIOD/2);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    #1;
    pulse(1);
    pulse(2);
    mode = 2'b11;
    pulse(1);
    rst = 1'b0;
    #1;
    check("R1 latch after reset", fb_b, 1'b0);
    mode = 2'b01;
    #1;
    check("R1 flop after reset", fb_b, 1'b0);
    check("R9 buried pin low", pin_b, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      logic [9:0] v;
      v = VEC[i];
      mode = v[9:8]; clk_sel = v[7]; invert = v[6]; src_pin = v[5];
      sum_in = v[4]; nbr_pin = v[3];
      #1;
      pulse(int'(v[2:1]));
      #1;
      check($sformatf("R2-R8 vector %0d", i), fb_b, v[0]);
      check("R9 buried pin stays low", pin_b, 1'b0);
    end

    // R1 reset clears both states mid-run (flop and latch both hold 1 here)
    clk_sel = 1'b0; src_pin = 1'b0; invert = 1'b0; sum_in = 1'b1;
    rst = 1'b1; mode = 2'b11;
    #1; pulse(1);
    check("R1 latch cleared", fb_b, 1'b0);
    mode = 2'b01;
    #1;
    check("R1 flop cleared", fb_b, 1'b0);
    rst = 1'b0;

    // R6 transparency while high
    mode = 2'b11; sum_in = 1'b0;
    #1;
    gclk[0] = 1'b1;
    sum_in = 1'b1; #1;
    check("R6 transparent high 1", fb_b, 1'b1);
    sum_in = 1'b0; #1;
    check("R6 transparent high 0", fb_b, 1'b0);
    sum_in = 1'b1; #1;
    gclk[0] = 1'b0; #1;
    sum_in = 1'b0; #1;
    check("R6 hold after close", fb_b, 1'b1);
    #(CLK_PERIOD/2);

    // R2 pass-through follows input without an edge
    mode = 2'b00; invert = 1'b0; sum_in = 1'b1; #1;
    check("R2 pass follows 1", fb_b, 1'b1);
    sum_in = 1'b0; #1;
    check("R2 pass follows 0", fb_b, 1'b0);

    // R9 pin variant: pin mirrors feedback, src_pin ignored
    mode = 2'b00; src_pin = 1'b1; sum_in = 1'b1; nbr_pin = 1'b0; invert = 1'b0;
    #1;
    check("R9 pin variant fb ignores src_pin", fb_p, 1'b1);
    check("R9 pin variant pin equals fb", pin_p, 1'b1);
    mode = 2'b01; sum_in = 1'b0; nbr_pin = 1'b1;
    #1; pulse(1); #1;
    check("R9 pin variant loads sum not pin", fb_p, 1'b0);
    check("R9 pin variant pin after load", pin_p, 1'b0);
    check("R8 buried loads pin", fb_b, 1'b1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule